// File: doc/BRIEF.md
# HDLC frame buffer register interface

This block sits between a processor bus and the byte-level ports of an HDLC transmit framer and an HDLC receive framer. The processor side is a small slave port: a 3-bit address, 8-bit write and read data, a strobe, a write enable and an acknowledge. Behind it are two byte FIFOs, each 128 deep. One holds a frame waiting to be sent and the other holds received frames. On top of the FIFOs the block handles whole frames. Software loads a complete frame and then starts it. The received frame is presented together with its length. A frame can be discarded in a single write. A partial frame cut short by the line is removed without software help.

Toward the framers the block uses a valid/pop byte handshake for transmit and a push/end/abort strobe set for receive. Two interrupt lines report that a transmit has finished and that a received frame is waiting, so software can work either from interrupts or by polling. The block uses one clock. Its asynchronous active-low reset is released synchronously inside the block. Every register reads as zero after reset.

Top module: `hdlc_buf_regif`

## Requirements
- R1: After reset, all five register addresses read 0x00, both interrupt lines are low and the transmit byte valid is low. The map is Tx control/status at 0x0, Tx data at 0x1, Rx control/status at 0x2, Rx data at 0x3 and Rx length at 0x4.
- R2: For every access, acknowledge is high for exactly one cycle, starting in the cycle after the strobe is first sampled. A strobe held through that cycle does not start a second access.
- R3: Bytes written to 0x1 are presented to the transmit framer in write order once the frame is started, one byte per pop. The last byte carries the last-byte marker. The Tx control/status bits are: bit0 done (read), bit1 start (write), bit2 abort (write), bit3 aborted (read), bit4 overflow (read), bit5 checksum enable (write).
- R4: Tx done (bit0 of 0x0) and its interrupt go high once a started frame has been fully popped. Tx done clears on the next write to 0x1.
- R5: Between start and Tx done, writes to 0x1 are ignored and nothing is added to the transmit FIFO.
- R6: Writing 1 to the abort bit does four things: it empties the transmit FIFO, pulses the framer abort output for one cycle, sets Tx done, and sets the aborted bit. The aborted bit clears when 0x0 is read.
- R7: Write-only bits read as 0. The checksum-enable bit drives its output level. The Tx data address 0x1 reads as 0x00.
- R8: A write to 0x1 while the transmit FIFO holds 128 bytes is discarded and sets bit4 of 0x0. That bit clears when 0x0 is read.
- R9: Received bytes are read from 0x3 in arrival order. Rx ready (bit0 of 0x2) and its interrupt rise when the framer ends a non-empty frame. They fall when the frame's last byte is read. The Rx control/status bits are: bit0 ready, bit1 drop (write), bit2 frame error, bit3 aborted, bit4 overflow.
- R10: While Rx ready is set, 0x4 returns the byte count of the presented frame. It returns 0 after the first read of 0x3 for that frame and whenever no frame is presented.
- R11: Writing 1 to the drop bit discards the unread bytes of the presented frame. Bytes of later frames are not affected.
- R12: A frame that completes while another is presented waits and is presented once the first is consumed or dropped. The frame error bit belongs to the presented frame.
- R13: A framer abort discards the partial frame's bytes and sets the Rx aborted bit. That bit clears when 0x2 is read.
- R14: A byte pushed while the receive FIFO holds 128 bytes is discarded and sets Rx overflow. Rx overflow clears on a write of the drop bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_stb | input | 1 | Access strobe |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_adr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid with acknowledge |
| bus_ack | output | 1 | Access acknowledge |
| irq_tx_done | output | 1 | Transmit finished |
| irq_rx_ready | output | 1 | Received frame waiting |
| txf_valid | output | 1 | A transmit byte is offered |
| txf_byte | output | 8 | Offered transmit byte |
| txf_last | output | 1 | Offered byte ends the frame |
| txf_pop | input | 1 | Framer takes the offered byte |
| tx_abort | output | 1 | One-cycle request to send an abort |
| tx_fcs_en | output | 1 | Checksum enable level |
| rxf_push | input | 1 | Framer delivers a received byte |
| rxf_byte | input | 8 | Received byte |
| rxf_end | input | 1 | Frame end, never in a push cycle |
| rxf_err | input | 1 | Frame error, qualified by rxf_end |
| rxf_abort | input | 1 | Frame aborted on the line |

## Verification
An access is sampled at the clock edge where the strobe is first seen. Acknowledge, read data, status changes and read side effects all appear right after that same edge. A framer pop or push is likewise registered at its edge. Tx done follows one edge after the final pop, because the empty FIFO is observed first. Rx ready follows directly at the end-strobe edge. The bench drives every input at falling edges and reads outputs at the falling edge after the relevant rising edge. For Tx done it waits several cycles before polling, so each sample lands after every register on the path has updated.

// File: rtl/hdlc_buf_pkg.sv
package hdlc_buf_pkg;

  typedef enum logic [2:0] {
    SEL_TX_CSR = 3'd0,
    SEL_TX_DAT = 3'd1,
    SEL_RX_CSR = 3'd2,
    SEL_RX_DAT = 3'd3,
    SEL_RX_LEN = 3'd4
  } reg_sel_e;

  // Tx control/status bit positions
  localparam int TXB_DONE  = 0;
  localparam int TXB_START = 1;
  localparam int TXB_ABORT = 2;
  localparam int TXB_ABTD  = 3;
  localparam int TXB_OVF   = 4;
  localparam int TXB_FCS   = 5;

  // Rx control/status bit positions
  localparam int RXB_RDY  = 0;
  localparam int RXB_DROP = 1;
  localparam int RXB_ERR  = 2;
  localparam int RXB_ABTD = 3;
  localparam int RXB_OVF  = 4;

endpackage

// File: rtl/hdlc_byte_fifo.sv
module hdlc_byte_fifo #(
  parameter int DW = 8,
  parameter int AW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  input  logic          pop,
  input  logic          skip,
  input  logic [AW:0]   skip_n,
  input  logic          rewind,
  input  logic [AW:0]   rewind_ptr,
  output logic [DW-1:0] head,
  output logic [AW:0]   count,
  output logic          full,
  output logic          empty,
  output logic [AW:0]   wr_ptr
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [AW:0]   wr_q, wr_d, rd_q, rd_d;

  always_comb begin
    wr_d = wr_q;
    if (rewind)    wr_d = rewind_ptr;
    else if (push) wr_d = wr_q + 1'b1;
    rd_d = rd_q;
    if (skip)     rd_d = rd_q + skip_n;
    else if (pop) rd_d = rd_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q <= '0;
      rd_q <= '0;
    end else begin
      wr_q <= wr_d;
      rd_q <= rd_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !rewind) mem[wr_q[AW-1:0]] <= wdata;
  end

  assign head   = mem[rd_q[AW-1:0]];
  assign count  = wr_q - rd_q;
  assign full   = (count == (AW+1)'(DEPTH));
  assign empty  = (count == '0);
  assign wr_ptr = wr_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full); // R8
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty); // R9
  AST_SKIP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    skip |-> (skip_n <= count)); // R11
  AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    count <= (AW+1)'(DEPTH)); // R14
endmodule

// File: rtl/hdlc_tx_ctrl.sv
module hdlc_tx_ctrl import hdlc_buf_pkg::*; #(
  parameter int AW = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_dat,
  input  logic       wr_csr,
  input  logic       rd_csr,
  input  logic [7:0] wdata,
  input  logic       txf_pop,
  output logic [7:0] csr_rd,
  output logic       txf_valid,
  output logic [7:0] txf_byte,
  output logic       txf_last,
  output logic       tx_abort,
  output logic       tx_fcs_en,
  output logic       irq
);
  logic busy_q, busy_d, done_q, done_d, abtd_q, abtd_d;
  logic ovf_q, ovf_d, fcs_q, fcs_d, abort_q;
  logic push, pop, ovf_set, abort_req, start_req;
  logic [AW:0] count, wr_ptr;
  logic full, empty;

  assign push      = wr_dat && !busy_q && !full;
  assign ovf_set   = wr_dat && !busy_q && full;
  assign abort_req = wr_csr && wdata[TXB_ABORT];
  assign start_req = wr_csr && wdata[TXB_START] && !abort_req;
  assign txf_valid = busy_q && !empty;
  assign pop       = txf_pop && txf_valid && !abort_req;
  assign txf_last  = txf_valid && (count == (AW+1)'(1));

  hdlc_byte_fifo #(.DW(8), .AW(AW)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .push(push), .wdata(wdata), .pop(pop),
    .skip(abort_req), .skip_n(count),
    .rewind(1'b0), .rewind_ptr('0),
    .head(txf_byte), .count(count), .full(full), .empty(empty),
    .wr_ptr(wr_ptr)
  );

  always_comb begin
    busy_d = busy_q;
    done_d = done_q;
    abtd_d = abtd_q;
    ovf_d  = ovf_q;
    fcs_d  = fcs_q;
    if (wr_dat && !busy_q) done_d = 1'b0;
    if (abort_req) begin
      busy_d = 1'b0;
      done_d = 1'b1;
    end else if (start_req) begin
      busy_d = 1'b1;
      done_d = 1'b0;
    end else if (busy_q && empty) begin
      busy_d = 1'b0;
      done_d = 1'b1;
    end
    if (rd_csr)    abtd_d = 1'b0;
    if (abort_req) abtd_d = 1'b1;
    if (rd_csr)    ovf_d  = 1'b0;
    if (ovf_set)   ovf_d  = 1'b1;
    if (wr_csr)    fcs_d  = wdata[TXB_FCS];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      abtd_q  <= 1'b0;
      ovf_q   <= 1'b0;
      fcs_q   <= 1'b0;
      abort_q <= 1'b0;
    end else begin
      busy_q  <= busy_d;
      done_q  <= done_d;
      abtd_q  <= abtd_d;
      ovf_q   <= ovf_d;
      fcs_q   <= fcs_d;
      abort_q <= abort_req;
    end
  end

  always_comb begin
    csr_rd           = '0;
    csr_rd[TXB_DONE] = done_q;
    csr_rd[TXB_ABTD] = abtd_q;
    csr_rd[TXB_OVF]  = ovf_q;
  end

  assign tx_abort  = abort_q;
  assign tx_fcs_en = fcs_q;
  assign irq       = done_q;

  AST_DONE_AFTER_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> done_q); // R4
  AST_LOCK_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> !done_q); // R5
  AST_ABORT_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    abort_q |-> (empty && !busy_q && done_q)); // R6
  AST_PTR_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> (wr_ptr != $past(wr_ptr))); // R3
endmodule

// File: rtl/hdlc_rx_ctrl.sv
module hdlc_rx_ctrl import hdlc_buf_pkg::*; #(
  parameter int AW = 7
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rd_dat,
  input  logic        rd_csr,
  input  logic        drop_req,
  input  logic        rxf_push,
  input  logic [7:0]  rxf_byte,
  input  logic        rxf_end,
  input  logic        rxf_err,
  input  logic        rxf_abort,
  output logic [7:0]  csr_rd,
  output logic [7:0]  dat_rd,
  output logic [AW:0] len_rd,
  output logic        irq
);
  logic        rdy_q, rdy_d, err_q, err_d, seen_q, seen_d;
  logic        pv_q, pv_d, perr_q, perr_d, abtd_q, abtd_d, ovf_q, ovf_d;
  logic [AW:0] len_q, len_d, rem_q, rem_d, plen_q, plen_d;
  logic [AW:0] cur_q, cur_d, start_q, start_d;
  logic [AW:0] count, wr_ptr;
  logic        full, empty;
  logic        push, pop, skip, release_f, end_ok, lose, rewind, ovf_set;

  assign push      = rxf_push && !full && !rxf_abort;
  assign ovf_set   = rxf_push && full;
  assign pop       = rd_dat && rdy_q && (rem_q != '0);
  assign skip      = drop_req && rdy_q;
  assign release_f = rdy_q && (skip || (pop && rem_q == (AW+1)'(1)));
  assign end_ok    = rxf_end && !rxf_abort && (cur_q != '0);

  hdlc_byte_fifo #(.DW(8), .AW(AW)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .push(push), .wdata(rxf_byte), .pop(pop),
    .skip(skip), .skip_n(rem_q),
    .rewind(rewind), .rewind_ptr(start_q),
    .head(dat_rd), .count(count), .full(full), .empty(empty),
    .wr_ptr(wr_ptr)
  );

  always_comb begin
    rdy_d = rdy_q;  len_d = len_q;   rem_d = rem_q;   err_d = err_q;
    seen_d = seen_q; pv_d = pv_q;    plen_d = plen_q; perr_d = perr_q;
    cur_d = cur_q;  start_d = start_q;
    abtd_d = abtd_q; ovf_d = ovf_q;
    lose = 1'b0;
    rewind = 1'b0;
    if (pop) begin
      rem_d  = rem_q - 1'b1;
      seen_d = 1'b1;
    end
    if (release_f) begin
      if (pv_q) begin
        len_d  = plen_q;
        rem_d  = plen_q;
        err_d  = perr_q;
        seen_d = 1'b0;
        pv_d   = 1'b0;
      end else begin
        rdy_d = 1'b0;
        rem_d = '0;
      end
    end
    if (push) cur_d = cur_q + 1'b1;
    if (end_ok) begin
      if (!rdy_d) begin
        rdy_d  = 1'b1;
        len_d  = cur_q;
        rem_d  = cur_q;
        err_d  = rxf_err;
        seen_d = 1'b0;
      end else if (!pv_d) begin
        pv_d   = 1'b1;
        plen_d = cur_q;
        perr_d = rxf_err;
      end else begin
        lose = 1'b1;
      end
      cur_d   = '0;
      rewind  = lose;
      start_d = lose ? start_q : wr_ptr;
    end
    if (rxf_abort) begin
      rewind = 1'b1;
      cur_d  = '0;
    end
    if (rd_csr)    abtd_d = 1'b0;
    if (rxf_abort) abtd_d = 1'b1;
    if (drop_req)  ovf_d  = 1'b0;
    if (ovf_set || lose) ovf_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q <= 1'b0;  len_q <= '0;  rem_q <= '0;  err_q <= 1'b0;
      seen_q <= 1'b0; pv_q <= 1'b0; plen_q <= '0; perr_q <= 1'b0;
      cur_q <= '0;    start_q <= '0;
      abtd_q <= 1'b0; ovf_q <= 1'b0;
    end else begin
      rdy_q <= rdy_d;  len_q <= len_d;  rem_q <= rem_d;   err_q <= err_d;
      seen_q <= seen_d; pv_q <= pv_d;   plen_q <= plen_d; perr_q <= perr_d;
      cur_q <= cur_d;  start_q <= start_d;
      abtd_q <= abtd_d; ovf_q <= ovf_d;
    end
  end

  always_comb begin
    csr_rd           = '0;
    csr_rd[RXB_RDY]  = rdy_q;
    csr_rd[RXB_ERR]  = rdy_q && err_q;
    csr_rd[RXB_ABTD] = abtd_q;
    csr_rd[RXB_OVF]  = ovf_q;
  end

  assign len_rd = (rdy_q && !seen_q) ? len_q : '0;
  assign irq    = rdy_q;

  AST_RDY_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_q |-> (rem_q != '0 && !empty)); // R9
  AST_REM_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_q |-> (rem_q <= count)); // R11
  AST_IDLE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    !rdy_q |-> (rem_q == '0 && !pv_q)); // R12
  AST_END_NOT_WITH_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    rxf_end |-> !rxf_push); // R9
endmodule

// File: rtl/hdlc_buf_regif.sv
module hdlc_buf_regif import hdlc_buf_pkg::*; #(
  parameter int FIFO_AW = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_stb,
  input  logic       bus_we,
  input  logic [2:0] bus_adr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       bus_ack,
  output logic       irq_tx_done,
  output logic       irq_rx_ready,
  output logic       txf_valid,
  output logic [7:0] txf_byte,
  output logic       txf_last,
  input  logic       txf_pop,
  output logic       tx_abort,
  output logic       tx_fcs_en,
  input  logic       rxf_push,
  input  logic [7:0] rxf_byte,
  input  logic       rxf_end,
  input  logic       rxf_err,
  input  logic       rxf_abort
);
  logic [1:0] rst_sync_q;
  logic       rst_i_n;
  logic       ack_q, take, acc_wr, acc_rd;
  logic [7:0] rdata_q, rdata_d;
  logic [7:0] tx_csr, rx_csr, rx_dat;
  logic [FIFO_AW:0] rx_len;
  reg_sel_e   sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  assign take   = bus_stb && !ack_q;
  assign acc_wr = take && bus_we;
  assign acc_rd = take && !bus_we;
  assign sel    = reg_sel_e'(bus_adr);

  hdlc_tx_ctrl #(.AW(FIFO_AW)) u_tx (
    .clk(clk), .rst_n(rst_i_n),
    .wr_dat(acc_wr && sel == SEL_TX_DAT),
    .wr_csr(acc_wr && sel == SEL_TX_CSR),
    .rd_csr(acc_rd && sel == SEL_TX_CSR),
    .wdata(bus_wdata), .txf_pop(txf_pop),
    .csr_rd(tx_csr), .txf_valid(txf_valid), .txf_byte(txf_byte),
    .txf_last(txf_last), .tx_abort(tx_abort), .tx_fcs_en(tx_fcs_en),
    .irq(irq_tx_done)
  );

  hdlc_rx_ctrl #(.AW(FIFO_AW)) u_rx (
    .clk(clk), .rst_n(rst_i_n),
    .rd_dat(acc_rd && sel == SEL_RX_DAT),
    .rd_csr(acc_rd && sel == SEL_RX_CSR),
    .drop_req(acc_wr && sel == SEL_RX_CSR && bus_wdata[RXB_DROP]),
    .rxf_push(rxf_push), .rxf_byte(rxf_byte), .rxf_end(rxf_end),
    .rxf_err(rxf_err), .rxf_abort(rxf_abort),
    .csr_rd(rx_csr), .dat_rd(rx_dat), .len_rd(rx_len), .irq(irq_rx_ready)
  );

  always_comb begin
    case (sel)
      SEL_TX_CSR: rdata_d = tx_csr;
      SEL_RX_CSR: rdata_d = rx_csr;
      SEL_RX_DAT: rdata_d = rx_dat;
      SEL_RX_LEN: rdata_d = 8'(rx_len);
      default:    rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      ack_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      ack_q <= take;
      if (acc_rd) rdata_q <= rdata_d;
    end
  end

  assign bus_ack   = ack_q;
  assign bus_rdata = rdata_q;

  AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_i_n)
    bus_ack |=> !bus_ack); // R2
  AST_ACK_AFTER_STB: assert property (@(posedge clk) disable iff (!rst_i_n)
    bus_ack |-> $past(bus_stb)); // R2
endmodule

// File: tb/hdlc_buf_regif_bench.sv
module hdlc_buf_regif_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       bus_stb, bus_we;
  logic [2:0] bus_adr;
  logic [7:0] bus_wdata, bus_rdata;
  logic       bus_ack, irq_tx_done, irq_rx_ready;
  logic       txf_valid, txf_last, txf_pop, tx_abort, tx_fcs_en;
  logic [7:0] txf_byte, rxf_byte;
  logic       rxf_push, rxf_end, rxf_err, rxf_abort;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  hdlc_buf_regif u_hdlc_buf_regif (
    .clk(clk), .rst_n(rst_n),
    .bus_stb(bus_stb), .bus_we(bus_we), .bus_adr(bus_adr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack),
    .irq_tx_done(irq_tx_done), .irq_rx_ready(irq_rx_ready),
    .txf_valid(txf_valid), .txf_byte(txf_byte), .txf_last(txf_last),
    .txf_pop(txf_pop), .tx_abort(tx_abort), .tx_fcs_en(tx_fcs_en),
    .rxf_push(rxf_push), .rxf_byte(rxf_byte), .rxf_end(rxf_end),
    .rxf_err(rxf_err), .rxf_abort(rxf_abort)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_stb = 1'b1; bus_we = 1'b1; bus_adr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_stb = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_stb = 1'b1; bus_we = 1'b0; bus_adr = a;
    @(posedge clk);
    @(negedge clk);
    d = bus_rdata;
    bus_stb = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [2:0] a, input logic [7:0] exp);
    logic [7:0] v;
    bus_rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic pull(output logic [7:0] b, output logic l, output logic v);
    @(negedge clk);
    v = txf_valid; b = txf_byte; l = txf_last;
    txf_pop = 1'b1;
    @(negedge clk);
    txf_pop = 1'b0;
  endtask

  task automatic push_byte(input logic [7:0] b);
    @(negedge clk);
    rxf_push = 1'b1; rxf_byte = b;
    @(negedge clk);
    rxf_push = 1'b0;
  endtask

  task automatic end_frame(input logic e);
    @(negedge clk);
    rxf_end = 1'b1; rxf_err = e;
    @(negedge clk);
    rxf_end = 1'b0; rxf_err = 1'b0;
  endtask

  task automatic t_reset;
    for (int a = 0; a < 5; a++) rd_chk("R1 reg reads zero", 3'(a), 8'h00);
    chk("R1 irq_tx_done low", irq_tx_done, 0);
    chk("R1 irq_rx_ready low", irq_rx_ready, 0);
    chk("R1 txf_valid low", txf_valid, 0);
    @(negedge clk);
    bus_stb = 1'b1; bus_we = 1'b0; bus_adr = 3'd2;
    #1 chk("R2 no ack before edge", bus_ack, 0);
    @(posedge clk); #1 chk("R2 ack after first edge", bus_ack, 1);
    @(posedge clk); #1 chk("R2 ack single cycle with held strobe", bus_ack, 0);
    @(negedge clk); bus_stb = 1'b0;
    @(posedge clk); #1 chk("R2 no second access", bus_ack, 0);
  endtask

  task automatic t_tx_basic;
    logic [7:0] b; logic l, v;
    bus_wr(3'd1, 8'h11); bus_wr(3'd1, 8'h22); bus_wr(3'd1, 8'h33);
    rd_chk("R4 done low before start", 3'd0, 8'h00);
    bus_wr(3'd0, 8'h02);
    bus_wr(3'd1, 8'h99);
    pull(b, l, v); chk("R3 byte0", {v, l, b}, {1'b1, 1'b0, 8'h11});
    pull(b, l, v); chk("R3 byte1", {v, l, b}, {1'b1, 1'b0, 8'h22});
    pull(b, l, v); chk("R3 byte2 last", {v, l, b}, {1'b1, 1'b1, 8'h33});
    repeat (3) @(negedge clk);
    chk("R5 locked write not queued", txf_valid, 0);
    chk("R4 irq after drain", irq_tx_done, 1);
    rd_chk("R4 done bit", 3'd0, 8'h01);
    bus_wr(3'd1, 8'h44);
    chk("R4 done clears on data write", irq_tx_done, 0);
    bus_wr(3'd0, 8'h02);
    pull(b, l, v); chk("R3 next frame byte", {v, l, b}, {1'b1, 1'b1, 8'h44});
    repeat (3) @(negedge clk);
  endtask

  task automatic t_tx_abort;
    bus_wr(3'd1, 8'h55); bus_wr(3'd1, 8'h66);
    bus_wr(3'd0, 8'h02);
    bus_wr(3'd0, 8'h04);
    chk("R6 abort pulse", tx_abort, 1);
    @(negedge clk);
    chk("R6 abort pulse one cycle", tx_abort, 0);
    chk("R6 fifo flushed", txf_valid, 0);
    rd_chk("R6 done and aborted", 3'd0, 8'h09);
    rd_chk("R6 aborted clears on read", 3'd0, 8'h01);
  endtask

  task automatic t_fcs;
    bus_wr(3'd0, 8'h20);
    chk("R7 checksum enable level", tx_fcs_en, 1);
    rd_chk("R7 write-only bits read zero", 3'd0, 8'h01);
    rd_chk("R7 tx data reads zero", 3'd1, 8'h00);
    bus_wr(3'd0, 8'h00);
    chk("R7 checksum enable off", tx_fcs_en, 0);
  endtask

  task automatic t_tx_ovf;
    logic [7:0] b; logic l, v;
    int bad = 0;
    for (int i = 0; i < 129; i++) bus_wr(3'd1, 8'(i + 3));
    rd_chk("R8 overflow bit", 3'd0, 8'h10);
    bus_wr(3'd0, 8'h02);
    for (int i = 0; i < 128; i++) begin
      pull(b, l, v);
      if (!v || b != 8'(i + 3) || l != (i == 127)) bad++;
    end
    chk("R8 first 128 bytes intact", bad, 0);
    repeat (3) @(negedge clk);
    chk("R8 extra byte discarded", txf_valid, 0);
    rd_chk("R8 overflow cleared by read", 3'd0, 8'h01);
  endtask

  task automatic t_rx_basic;
    push_byte(8'hC1); push_byte(8'hC2); push_byte(8'hC3);
    rd_chk("R9 not ready before end", 3'd2, 8'h00);
    end_frame(1'b0);
    chk("R9 irq on frame end", irq_rx_ready, 1);
    rd_chk("R9 ready bit", 3'd2, 8'h01);
    rd_chk("R10 length", 3'd4, 8'h03);
    rd_chk("R9 byte0", 3'd3, 8'hC1);
    rd_chk("R10 length gone after read", 3'd4, 8'h00);
    rd_chk("R9 byte1", 3'd3, 8'hC2);
    rd_chk("R9 byte2", 3'd3, 8'hC3);
    rd_chk("R9 ready falls", 3'd2, 8'h00);
    chk("R9 irq falls", irq_rx_ready, 0);
  endtask

  task automatic t_rx_pending;
    push_byte(8'hF0); push_byte(8'hF1); end_frame(1'b1);
    push_byte(8'h77); end_frame(1'b0);
    rd_chk("R12 first frame with error", 3'd2, 8'h05);
    rd_chk("R12 first length", 3'd4, 8'h02);
    rd_chk("R12 first byte0", 3'd3, 8'hF0);
    rd_chk("R12 first byte1", 3'd3, 8'hF1);
    rd_chk("R12 second frame presented", 3'd2, 8'h01);
    rd_chk("R12 second length", 3'd4, 8'h01);
    rd_chk("R12 second byte", 3'd3, 8'h77);
    rd_chk("R12 idle", 3'd2, 8'h00);
  endtask

  task automatic t_rx_drop;
    for (int i = 0; i < 4; i++) push_byte(8'(8'hD0 + i));
    end_frame(1'b0);
    bus_wr(3'd2, 8'h02);
    rd_chk("R11 dropped frame gone", 3'd2, 8'h00);
    push_byte(8'hE0); push_byte(8'hE1); end_frame(1'b0);
    rd_chk("R11 next length", 3'd4, 8'h02);
    rd_chk("R11 next byte0", 3'd3, 8'hE0);
    rd_chk("R11 next byte1", 3'd3, 8'hE1);
  endtask

  task automatic t_rx_abort;
    push_byte(8'hA1); push_byte(8'hA2);
    @(negedge clk); rxf_abort = 1'b1;
    @(negedge clk); rxf_abort = 1'b0;
    chk("R13 no frame after abort", irq_rx_ready, 0);
    rd_chk("R13 aborted bit", 3'd2, 8'h08);
    rd_chk("R13 aborted clears on read", 3'd2, 8'h00);
    push_byte(8'h5A); end_frame(1'b0);
    rd_chk("R13 following length", 3'd4, 8'h01);
    rd_chk("R13 partial bytes discarded", 3'd3, 8'h5A);
  endtask

  task automatic t_rx_ovf;
    for (int i = 0; i < 129; i++) push_byte(8'(i));
    rd_chk("R14 overflow bit", 3'd2, 8'h10);
    end_frame(1'b0);
    rd_chk("R14 capped length", 3'd4, 8'h80);
    bus_wr(3'd2, 8'h02);
    rd_chk("R14 drop clears overflow", 3'd2, 8'h00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    bus_stb = 1'b0; bus_we = 1'b0; bus_adr = '0; bus_wdata = '0;
    txf_pop = 1'b0; rxf_push = 1'b0; rxf_byte = '0;
    rxf_end = 1'b0; rxf_err = 1'b0; rxf_abort = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_tx_basic();
    t_tx_abort();
    t_fcs();
    t_tx_ovf();
    t_rx_basic();
    t_rx_pending();
    t_rx_drop();
    t_rx_abort();
    t_rx_ovf();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule